// File: doc/BRIEF.md
# Three-Term Karatsuba Polynomial Multiplier

This block multiplies two quadratic polynomials with unsigned W-bit coefficients and returns the five coefficients of their degree-4 product. It does not form all nine cross products of the schoolbook method. Instead it forms three single-term products and three products of pairwise coefficient sums, six products in total. The middle coefficients are then recovered by subtraction. The odd term count is handled directly with pairwise sums, with no split into halves.

The block is purely combinational. An optional output treats the polynomial variable as 2^W and folds the five coefficients into one integer. With that output enabled, the block doubles as a 3W x 3W unsigned integer multiplier with a 6W-bit result. Each coefficient port is wide enough to hold its largest possible value, so no coefficient ever wraps.

Top module: `kara3_poly_mul`

## Requirements
- R1: Operand coefficient k (k = 0, 1, 2) occupies bits [k*W+W-1 : k*W] of its operand port, so the constant term sits in the least significant field.
- R2: `coef0_o` equals a0*b0 and `coef4_o` equals a2*b2, each 2W bits wide.
- R3: `coef1_o` equals a0*b1 + a1*b0 and `coef3_o` equals a1*b2 + a2*b1, each 2W+1 bits wide and exact.
- R4: `coef2_o` equals a0*b2 + a1*b1 + a2*b0, 2W+2 bits wide, with no wrap at its largest value.
- R5: When the integer option is enabled (default), `prod_o` equals the unsigned product of `opa_i` and `opb_i`, 6W bits wide.
- R6: If either operand is zero, every coefficient output and `prod_o` are zero.
- R7: With all operand bits set, each coefficient takes its maximum value: (2^W-1)^2 times 1, 2, 3, 2 and 1 for coefficients 0 to 4.
- R8: The sum of the five coefficients equals (a0+a1+a2)*(b0+b1+b2).
- R9: The outputs follow the operands with no clock, so new operands give new results within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 3*W | Packed coefficients of A; a0 is in the lowest field |
| opb_i | input | 3*W | Packed coefficients of B; b0 is in the lowest field |
| coef0_o | output | 2*W | Constant coefficient of the product |
| coef1_o | output | 2*W+1 | Coefficient of x |
| coef2_o | output | 2*W+2 | Coefficient of x^2 |
| coef3_o | output | 2*W+1 | Coefficient of x^3 |
| coef4_o | output | 2*W | Coefficient of x^4 |
| prod_o | output | 6*W | Integer product with x = 2^W; zero when the option is disabled |

## Verification
The bench applies the following cases:
- **All-ones operands.** These drive `coef2_o` to three times the largest single product. A design that sized that coefficient like the others, or that subtracted in a width that is too narrow, would lose the top bit there.
- **Single non-zero field.** Operands with exactly one non-zero coefficient field expose a swapped field order or a wrong pair assignment. In that case a product lands in the wrong coefficient.
- **One operand zero.** Each side is zeroed while the other stays full. This catches a subtraction that leaves a borrow behind.
- **Random operands.** These are compared against a nine-product reference and against plain integer multiplication. Any shift error in the integer fold shows up as a mismatch in the upper bits of `prod_o`.

// File: rtl/kara3_pkg.sv
package kara3_pkg;

  localparam int unsigned TERMS = 3;
  localparam int unsigned PAIRS = 3;

  // Pair index -> lower coefficient index: pairs are (0,1), (0,2), (1,2)
  function automatic int unsigned pair_lo(input int unsigned k);
    return (k == 2) ? 1 : 0;
  endfunction

  // Pair index -> upper coefficient index
  function automatic int unsigned pair_hi(input int unsigned k);
    return (k == 0) ? 1 : 2;
  endfunction

endpackage

// File: rtl/kara3_single_mul.sv
module kara3_single_mul #(
  parameter int unsigned W = 4
) (
  input  logic [3*W-1:0]          opa,
  input  logic [3*W-1:0]          opb,
  output logic [2:0][2*W-1:0]     dsng
);
  import kara3_pkg::*;

  localparam int unsigned PW = 2 * W;

  for (genvar k = 0; k < TERMS; k++) begin : g_sng
    logic [PW-1:0] ax, bx;
    assign ax = {{W{1'b0}}, opa[k*W +: W]};
    assign bx = {{W{1'b0}}, opb[k*W +: W]};
    assign dsng[k] = ax * bx;
  end

endmodule

// File: rtl/kara3_pair_mul.sv
module kara3_pair_mul #(
  parameter int unsigned W = 4
) (
  input  logic [3*W-1:0]          opa,
  input  logic [3*W-1:0]          opb,
  output logic [2:0][2*W+1:0]     dpair
);
  import kara3_pkg::*;

  localparam int unsigned SW = W + 1;
  localparam int unsigned PW = 2 * W + 2;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int unsigned LO = pair_lo(k);
    localparam int unsigned HI = pair_hi(k);
    logic [SW-1:0] sa, sb;
    logic [PW-1:0] sax, sbx;
    assign sa  = {1'b0, opa[LO*W +: W]} + {1'b0, opa[HI*W +: W]};
    assign sb  = {1'b0, opb[LO*W +: W]} + {1'b0, opb[HI*W +: W]};
    assign sax = {{(PW-SW){1'b0}}, sa};
    assign sbx = {{(PW-SW){1'b0}}, sb};
    assign dpair[k] = sax * sbx;
  end

endmodule

// File: rtl/kara3_combine.sv
module kara3_combine #(
  parameter int unsigned W      = 4,
  parameter bit          EN_INT = 1'b1
) (
  input  logic [2:0][2*W-1:0]     dsng,
  input  logic [2:0][2*W+1:0]     dpair,
  output logic [2*W-1:0]          coef0,
  output logic [2*W:0]            coef1,
  output logic [2*W+1:0]          coef2,
  output logic [2*W:0]            coef3,
  output logic [2*W-1:0]          coef4,
  output logic [6*W-1:0]          prod
);

  localparam int unsigned CW = 2 * W + 3;   // working width, one spare bit
  localparam int unsigned OW = 6 * W;

  logic [CW-1:0] s0, s1, s2, p01, p02, p12;
  logic [CW-1:0] c1w, c2w, c3w;

  assign s0  = {3'b000, dsng[0]};
  assign s1  = {3'b000, dsng[1]};
  assign s2  = {3'b000, dsng[2]};
  assign p01 = {1'b0, dpair[0]};
  assign p02 = {1'b0, dpair[1]};
  assign p12 = {1'b0, dpair[2]};

  // Middle coefficients recovered from pair products by subtraction
  assign c1w = p01 - s0 - s1;
  assign c3w = p12 - s1 - s2;
  assign c2w = p02 - s0 - s2 + s1;

  assign coef0 = dsng[0];
  assign coef4 = dsng[2];
  assign coef1 = c1w[2*W:0];
  assign coef3 = c3w[2*W:0];
  assign coef2 = c2w[2*W+1:0];

  if (EN_INT) begin : g_int
    logic [OW-1:0] e0, e1, e2, e3, e4;
    assign e0 = {{(OW-2*W){1'b0}},   coef0};
    assign e1 = {{(OW-2*W-1){1'b0}}, coef1};
    assign e2 = {{(OW-2*W-2){1'b0}}, coef2};
    assign e3 = {{(OW-2*W-1){1'b0}}, coef3};
    assign e4 = {{(OW-2*W){1'b0}},   coef4};
    assign prod = e0 + (e1 << W) + (e2 << (2*W)) + (e3 << (3*W)) + (e4 << (4*W));
  end else begin : g_no_int
    assign prod = '0;
  end

  // Each pair product holds both single products plus a non-negative cross term
  always_comb begin
    p_cross_nonneg_r3 : assert ((p01 >= s0 + s1) && (p12 >= s1 + s2) && (p02 >= s0 + s2))
      else $error("pair product below its single products");
    p_no_overflow_r4 : assert (c2w[CW-1:2*W+2] == '0)
      else $error("x^2 coefficient exceeds its port width");
  end

endmodule

// File: rtl/kara3_poly_mul.sv
module kara3_poly_mul #(
  parameter int unsigned W      = 4,
  parameter bit          EN_INT = 1'b1
) (
  input  logic [3*W-1:0] opa_i,
  input  logic [3*W-1:0] opb_i,
  output logic [2*W-1:0] coef0_o,
  output logic [2*W:0]   coef1_o,
  output logic [2*W+1:0] coef2_o,
  output logic [2*W:0]   coef3_o,
  output logic [2*W-1:0] coef4_o,
  output logic [6*W-1:0] prod_o
);

  localparam int unsigned EW = 2 * W + 4;   // width for the x = 1 evaluation

  logic [2:0][2*W-1:0] dsng;
  logic [2:0][2*W+1:0] dpair;

  kara3_single_mul #(.W(W)) u_sng (
    .opa  (opa_i),
    .opb  (opb_i),
    .dsng (dsng)
  );

  kara3_pair_mul #(.W(W)) u_pair (
    .opa   (opa_i),
    .opb   (opb_i),
    .dpair (dpair)
  );

  kara3_combine #(.W(W), .EN_INT(EN_INT)) u_comb (
    .dsng  (dsng),
    .dpair (dpair),
    .coef0 (coef0_o),
    .coef1 (coef1_o),
    .coef2 (coef2_o),
    .coef3 (coef3_o),
    .coef4 (coef4_o),
    .prod  (prod_o)
  );

  // Observation wires for the assertions: polynomials evaluated at x = 1
  logic [EW-1:0] sum_a, sum_b, eval_ab, eval_c;
  assign sum_a = EW'(opa_i[0 +: W]) + EW'(opa_i[W +: W]) + EW'(opa_i[2*W +: W]);
  assign sum_b = EW'(opb_i[0 +: W]) + EW'(opb_i[W +: W]) + EW'(opb_i[2*W +: W]);
  assign eval_ab = sum_a * sum_b;
  assign eval_c  = EW'(coef0_o) + EW'(coef1_o) + EW'(coef2_o) + EW'(coef3_o) + EW'(coef4_o);

  always_comb begin
    p_eval_one_r8 : assert (eval_c == eval_ab)
      else $error("coefficient sum differs from product at x = 1");
    p_zero_operand_r6 : assert (!((opa_i == '0) || (opb_i == '0)) ||
                               ((coef0_o | coef4_o) == '0 && coef1_o == '0 &&
                                coef2_o == '0 && coef3_o == '0 && prod_o == '0))
      else $error("zero operand gives non-zero result");
    p_low_field_r5 : assert (!EN_INT || prod_o[W-1:0] == coef0_o[W-1:0])
      else $error("integer product low field mismatch");
  end

endmodule

// File: tb/kara3_poly_mul_bench.sv
module kara3_poly_mul_bench;

  localparam int W  = 4;
  localparam int FM = (1 << W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [3*W-1:0] opa, opb;
  logic [2*W-1:0] c0, c4;
  logic [2*W:0]   c1, c3;
  logic [2*W+1:0] c2;
  logic [6*W-1:0] prod;

  kara3_poly_mul #(.W(W), .EN_INT(1'b1)) u_kara3_poly_mul (
    .opa_i (opa), .opb_i (opb),
    .coef0_o (c0), .coef1_o (c1), .coef2_o (c2), .coef3_o (c3), .coef4_o (c4),
    .prod_o (prod)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Scoreboard queues: expected coefficients, product, x=1 value, and a tag
  int    q_c0[$], q_c1[$], q_c2[$], q_c3[$], q_c4[$], q_ev[$];
  longint q_pr[$];
  string q_tag[$];

  task automatic chk(input string req, input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, tag, act, exp);
    end
  endtask

  // Driver: computes nine-product reference and pushes expectations
  task automatic drive(input logic [3*W-1:0] a, input logic [3*W-1:0] b, input string tag);
    int ac[3], bc[3], cc[5];
    int sa, sb;
    for (int k = 0; k < 3; k++) begin
      ac[k] = int'(a[k*W +: W]);
      bc[k] = int'(b[k*W +: W]);
    end
    for (int k = 0; k < 5; k++) cc[k] = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        cc[i+j] += ac[i] * bc[j];
    sa = ac[0] + ac[1] + ac[2];
    sb = bc[0] + bc[1] + bc[2];
    @(posedge clk);
    #1;
    opa = a;
    opb = b;
    q_c0.push_back(cc[0]); q_c1.push_back(cc[1]); q_c2.push_back(cc[2]);
    q_c3.push_back(cc[3]); q_c4.push_back(cc[4]);
    q_ev.push_back(sa * sb);
    q_pr.push_back(longint'(a) * longint'(b));
    q_tag.push_back(tag);
  endtask

  // Monitor: samples at the falling edge, away from the driving edge (R9)
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk("R2", t, longint'(c0), longint'(q_c0.pop_front()));
      chk("R3", t, longint'(c1), longint'(q_c1.pop_front()));
      chk("R4", t, longint'(c2), longint'(q_c2.pop_front()));
      chk("R3", t, longint'(c3), longint'(q_c3.pop_front()));
      chk("R2", t, longint'(c4), longint'(q_c4.pop_front()));
      chk("R5", t, longint'(prod), q_pr.pop_front());
      chk("R8", t, longint'(c0) + c1 + c2 + c3 + c4, longint'(q_ev.pop_front()));
    end
  end

  initial begin
    opa = '0;
    opb = '0;
    #2;
    // Reset state with zero operands (R6)
    chk("R6", "initial", longint'(prod) + c0 + c1 + c2 + c3 + c4, 0);

    drive('0, '0, "R6 both zero");
    drive('0, '1, "R6 a zero");
    drive('1, '0, "R6 b zero");
    drive('1, '1, "R7 all ones");
    // R7 explicit maxima
    @(negedge clk);
    #1;
    chk("R7", "max c2", longint'(c2), 3 * FM * FM);
    chk("R7", "max c1", longint'(c1), 2 * FM * FM);
    chk("R7", "max c0", longint'(c0), FM * FM);

    // R1: one non-zero field per operand, every field combination
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        drive(12'(FM) << (i*W), 12'(FM - 2) << (j*W), "R1 single field");

    // R1: field order distinguishes a0 from a2
    drive(12'h001, 12'h300, "R1 order");
    drive(12'h123, 12'h456, "R5 fixed");
    drive(12'hFFF, 12'h001, "R5 unit");

    // Random operands (R5, R8, R9 back-to-back changes)
    for (int n = 0; n < 300; n++)
      drive(12'($urandom), 12'($urandom), "random");

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule